// File: doc/BRIEF.md
# Port Input Conditioning Bank

This block sits between a group of port input pins and a programmable logic array. Each pin has its own conditioning cell, and a 2-bit code per pin selects how the pin reaches the array. The pin can pass straight through. It can be sampled into a flip-flop on each rising clock edge. It can also go through a transparent hold stage that follows the pin while a shared hold-enable input is high and freezes when that input drops.

A processor-side read bus returns the conditioned value of every cell, exactly as the array sees it. The bus needs no handshake and can be read at any moment. A parameter mask marks pins that are reserved for a boundary-scan test port. These pins never reach the array. Their raw value goes out on a separate test bus instead. The default bank serves three 8-bit ports, giving 24 pins, and the top four pins of the third port are bypassed.

Top module: `incond_bank`

## Requirements
- R1: A cell whose active mode code is 2'b00 drives its array output bit combinationally with the current pin value.
- R2: A cell whose active mode code is 2'b01 drives its array output bit with the pin value sampled at the most recent rising clock edge.
- R3: A cell whose active mode code is 2'b10 follows its pin combinationally while `hold_en` is high. While `hold_en` is low, it holds the pin value sampled at the last rising edge on which `hold_en` was high, or 0 if there has been no such edge since reset.
- R4: Mode code 2'b11 is reserved and behaves exactly like 2'b00.
- R5: `cpu_rd_data` always equals the conditioned array value of every cell, bit for bit, with no clock delay.
- R6: A synchronous active-high `rst` clears the sampled and held values to 0 and returns every cell to mode 2'b00.
- R7: For each pin set in `BYPASS_MASK` (default bits 23:20), the array output bit is 0 and the matching `test_out` bit carries the raw pin. `test_out` bits of pins that are not bypassed are 0.
- R8: The mode field of pin i sits at `mode_cfg[2i+1:2i]`. A new value becomes active at the next rising clock edge.
- R9: The mode field of a bypassed pin has no effect on `array_out`, `cpu_rd_data` or `test_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conditioning clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hold_en | input | 1 | Shared enable for the transparent hold path |
| pin_in | input | NUM_PINS | Raw pin values, one bit per pin |
| mode_cfg | input | 2*NUM_PINS | Per-pin mode codes, two bits each |
| array_out | output | NUM_PINS | Conditioned values toward the logic array |
| cpu_rd_data | output | NUM_PINS | Processor read bus of conditioned values |
| test_out | output | NUM_PINS | Raw values of bypassed pins, 0 elsewhere |

## Verification
Each mode is driven across the whole bank with random pin traffic. This separates a same-cycle path from a one-edge-late one: pass-through shows new values at once, while the sampled path lags by one edge. In hold mode, `hold_en` is toggled between edges, which shows the difference between following the pin and freezing it. A mixed pattern assigns different codes, including the reserved code, to neighbouring pins, so a swapped or misplaced mode field becomes visible. Resets are applied in the middle of traffic, and the bypassed pins receive every mode code, to check that they never leak into the array.

// File: rtl/incond_pkg.sv
package incond_pkg;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_SAMP  = 2'b01,
        MODE_HOLD  = 2'b10,
        MODE_RSVD  = 2'b11
    } cond_mode_e;

    localparam int MODE_BITS = 2;

endpackage

// File: rtl/incond_cell.sv
module incond_cell
    import incond_pkg::*;
#(
    parameter bit BYPASS = 1'b0
) (
    input  logic                 pin,
    input  logic                 hold_en,
    input  logic [MODE_BITS-1:0] mode,
    input  logic                 samp_q,
    input  logic                 hold_q,
    output logic                 cond_out
);

    logic sel_d;

    always_comb begin
        unique case (cond_mode_e'(mode))
            MODE_SAMP: sel_d = samp_q;
            MODE_HOLD: sel_d = hold_en ? pin : hold_q;
            default:   sel_d = pin;
        endcase
    end

    assign cond_out = BYPASS ? 1'b0 : sel_d;

endmodule

// File: rtl/incond_testmux.sv
module incond_testmux #(
    parameter int                  NUM_PINS    = 24,
    parameter logic [NUM_PINS-1:0] BYPASS_MASK = '0
) (
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] test_out
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_tap
        if (BYPASS_MASK[g]) begin : g_on
            assign test_out[g] = pin_in[g];
        end else begin : g_off
            assign test_out[g] = 1'b0;
        end
    end

endmodule

// File: rtl/incond_bank.sv
module incond_bank
    import incond_pkg::*;
#(
    parameter int                  NUM_PINS    = 24,
    parameter logic [NUM_PINS-1:0] BYPASS_MASK = 24'hF0_0000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          hold_en,
    input  logic [NUM_PINS-1:0]           pin_in,
    input  logic [MODE_BITS*NUM_PINS-1:0] mode_cfg,
    output logic [NUM_PINS-1:0]           array_out,
    output logic [NUM_PINS-1:0]           cpu_rd_data,
    output logic [NUM_PINS-1:0]           test_out
);

    localparam int MODE_W = MODE_BITS * NUM_PINS;

    typedef struct packed {
        logic [MODE_W-1:0]   mode;
        logic [NUM_PINS-1:0] samp;
        logic [NUM_PINS-1:0] hold;
    } bank_state_t;

    bank_state_t         st_d, st_q;
    logic [NUM_PINS-1:0] cond_w;
    logic [MODE_W-1:0]   mode_act_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.mode = mode_cfg;
            st_d.samp = pin_in & ~BYPASS_MASK;
            if (hold_en) begin
                st_d.hold = pin_in & ~BYPASS_MASK;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_act_q = st_q.mode;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_cell
        incond_cell #(
            .BYPASS (BYPASS_MASK[g])
        ) u_cell (
            .pin      (pin_in[g]),
            .hold_en  (hold_en),
            .mode     (st_q.mode[MODE_BITS*g +: MODE_BITS]),
            .samp_q   (st_q.samp[g]),
            .hold_q   (st_q.hold[g]),
            .cond_out (cond_w[g])
        );
    end

    incond_testmux #(
        .NUM_PINS    (NUM_PINS),
        .BYPASS_MASK (BYPASS_MASK)
    ) u_testmux (
        .pin_in   (pin_in),
        .test_out (test_out)
    );

    assign array_out   = cond_w;
    assign cpu_rd_data = cond_w;

endmodule

// File: rtl/incond_bank_chk.sv
module incond_bank_chk #(
    parameter int                  NUM_PINS    = 24,
    parameter logic [NUM_PINS-1:0] BYPASS_MASK = 24'hF0_0000
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  hold_en,
    input logic [NUM_PINS-1:0]   pin_in,
    input logic [2*NUM_PINS-1:0] mode_cfg,
    input logic [2*NUM_PINS-1:0] mode_act_q,
    input logic [NUM_PINS-1:0]   array_out,
    input logic [NUM_PINS-1:0]   test_out
);

    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    p_test_tap_r7: assert property (@(posedge clk) disable iff (rst)
        test_out == (pin_in & BYPASS_MASK));

    p_bypass_dark_r9: assert property (@(posedge clk) disable iff (rst)
        (array_out & BYPASS_MASK) == '0);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        if (!BYPASS_MASK[g]) begin : g_live
            p_pass_r1: assert property (@(posedge clk) disable iff (rst)
                (mode_act_q[2*g+:2] == 2'b00 || mode_act_q[2*g+:2] == 2'b11)
                |-> array_out[g] == pin_in[g]);

            p_samp_r8: assert property (@(posedge clk) disable iff (rst)
                (armed_q && $past(mode_cfg[2*g+:2]) == 2'b01)
                |-> array_out[g] == $past(pin_in[g]));

            p_hold_r3: assert property (@(posedge clk) disable iff (rst)
                (armed_q && !hold_en && !$past(hold_en)
                 && mode_act_q[2*g+:2] == 2'b10 && $past(mode_act_q[2*g+:2]) == 2'b10)
                |-> $stable(array_out[g]));
        end
    end

endmodule

bind incond_bank incond_bank_chk #(
    .NUM_PINS    (NUM_PINS),
    .BYPASS_MASK (BYPASS_MASK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold_en    (hold_en),
    .pin_in     (pin_in),
    .mode_cfg   (mode_cfg),
    .mode_act_q (mode_act_q),
    .array_out  (array_out),
    .test_out   (test_out)
);

// File: tb/incond_bank_test.sv
module incond_bank_test;

    localparam int               N    = 24;
    localparam logic [N-1:0]     MASK = 24'hF0_0000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           hold_en = 1'b0;
    logic [N-1:0]   pin_in = '0;
    logic [2*N-1:0] mode_cfg = '0;
    logic [N-1:0]   array_out, cpu_rd_data, test_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    int ref_mode [N];
    int ref_samp [N];
    int ref_hold [N];
    bit ref_chg  [N];

    always #10 clk = ~clk;

    incond_bank #(.NUM_PINS(N), .BYPASS_MASK(MASK)) uut (
        .clk, .rst, .hold_en, .pin_in, .mode_cfg,
        .array_out, .cpu_rd_data, .test_out
    );

    initial begin
        for (int i = 0; i < N; i++) begin
            ref_mode[i] = 0; ref_samp[i] = 0; ref_hold[i] = 0; ref_chg[i] = 0;
        end
    end

    // Behavioural model updated at each rising edge (R6, R8, R2, R3)
    always @(posedge clk) begin
        cycles++;
        for (int i = 0; i < N; i++) begin
            int nm;
            nm = (mode_cfg >> (2*i)) & 3;
            if (rst) begin
                ref_chg[i]  = (ref_mode[i] != 0);
                ref_mode[i] = 0; ref_samp[i] = 0; ref_hold[i] = 0;
            end else begin
                ref_chg[i]  = (ref_mode[i] != nm);
                ref_mode[i] = nm;
                ref_samp[i] = pin_in[i];
                if (hold_en) ref_hold[i] = pin_in[i];
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp, input int pin);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s pin %0d: actual %0d expected %0d at cycle %0d", tag, pin, act, exp, cycles);
        end
    endtask

    // Compare every pin at each falling edge
    always @(negedge clk) begin
        if (!done) begin
            for (int i = 0; i < N; i++) begin
                int exp_a, exp_t;
                string tag;
                if (MASK[i]) begin
                    exp_a = 0; exp_t = pin_in[i]; tag = "R7 R9";
                end else begin
                    exp_t = 0;
                    case (ref_mode[i])
                        1: begin exp_a = ref_samp[i]; tag = "R2"; end
                        2: begin exp_a = hold_en ? pin_in[i] : ref_hold[i]; tag = "R3"; end
                        3: begin exp_a = pin_in[i]; tag = "R4"; end
                        default: begin exp_a = pin_in[i]; tag = "R1"; end
                    endcase
                    if (ref_chg[i]) tag = {tag, " R8"};
                end
                check(tag, array_out[i], exp_a, i);
                check("R5", cpu_rd_data[i], exp_a, i);
                check("R7", test_out[i], exp_t, i);
            end
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #2;
            pin_in = N'($urandom);
            if (($urandom % 3) == 0) hold_en = ~hold_en;
        end
    endtask

    function automatic logic [2*N-1:0] all_mode(input logic [1:0] m);
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) v[2*i +: 2] = m;
        return v;
    endfunction

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        // R6: after reset, hold mode with enable low shows cleared value 0
        @(negedge clk); #2;
        rst = 0; hold_en = 0; mode_cfg = all_mode(2'b10); pin_in = '1;
        @(negedge clk);
        check("R6", int'(array_out & ~MASK), 0, -1);
        #2;
        // R1 pass-through
        mode_cfg = all_mode(2'b00); step(20);
        // R2 sampled
        mode_cfg = all_mode(2'b01); step(20);
        // R3 hold with enable toggling
        mode_cfg = all_mode(2'b10); step(30);
        // R4 reserved code
        mode_cfg = all_mode(2'b11); step(15);
        // mixed per-pin codes (R8 field positions, R9 bypassed pins get all codes)
        for (int r = 0; r < 6; r++) begin
            @(negedge clk); #2;
            mode_cfg = {$urandom, $urandom};
            step(8);
        end
        // reset in mid-traffic (R6)
        @(negedge clk); #2; rst = 1; step(2);
        @(negedge clk); #2; rst = 0; mode_cfg = all_mode(2'b01);
        step(10);
        @(negedge clk);
        finish_run();
    end

endmodule